// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control unit of a small 8-bit processor that has no pipeline and uses 16-bit instructions. It holds the instruction register, a step counter and a shift down-counter. From these it drives the strobes that steer the program counter, register file, ALU, memory and IO pins of a separate datapath. Each instruction starts with two fetch steps that read the low byte and then the high byte. The execute steps that follow are chosen by the 4-bit opcode in bits 15:12 and, for arithmetic and IO, by the 3-bit flags field in bits 2:0.

The datapath returns two status bits: whether ALU operand A is zero, and whether it is greater than zero as a signed value. The block uses them to decide conditional jumps. Shifts move one bit position per cycle. The step counter stalls while the internal down-counter runs out. A halt instruction raises a clock-gate output that stays high until reset. Every control output is decoded combinationally from registered state, so each step of an instruction can be seen on the pins.

Top module: `mc_sequencer`

## Requirements
- R1: A synchronous active-high `rst` clears the step counter, the instruction register, the shift counter and the halt state. The first cycle after `rst` falls is a low-byte fetch with only `pc_inc` asserted.
- R2: Every instruction begins with two fetch steps, each asserting `pc_inc` and nothing else. The first step captures `mem_rdata` as instruction bits 7:0 and the second captures bits 15:8.
- R3: Opcode 0000 with flags 000..110 takes three execute steps. The first asserts `rf_rd_en` and `alu_load`, with `rf_sel_a` = bits 8:6 and `rf_sel_b` = bits 5:3. ADDI (flags 000) instead reads bits 11:9 on A, asserts `alu_b_imm` and puts bits 8:3 sign-extended on `lit_data`. The second asserts `alu_exec` with `alu_op`: ADDI/ADD(001)→010, SUB(010)→011, OR(011)→001, AND(100)→000, NOT(101)→101, XOR(110)→110. The third asserts `alu_to_bus` and `rf_we` with `rf_waddr` = bits 11:9 and ends the instruction.
- R4: Opcode 0000 with flags 111, opcode 1011 and opcode 1010 have no effect: one execute step with every strobe low, then a new fetch.
- R5: Opcode 0100 takes one execute step. With flags bit 0 = 0 it asserts `in_to_bus` and `rf_we` to bits 11:9. With flags bit 0 = 1 it asserts `rf_rd_en` (A = bits 11:9) and `bus_to_out`.
- R6: Opcode 0001 asserts `mem_use_ir`, `mem_rd` and `rf_we` to bits 11:9. Opcode 0101 asserts `rf_rd_en` (A = bits 11:9), `mem_use_ir` and `mem_wr`. Both take one execute step with `addr_field` = bits 8:0.
- R7: Opcode 0011 asserts `rf_we` and `rf_wr_imm` in one execute step, with `lit_data` = bits 7:0 and `rf_waddr` = bits 11:9.
- R8: Conditional jumps read bits 11:9 into the ALU in their first execute step. In the second they assert `pc_load` with `addr_field` = bits 8:0 only if the condition holds: 1100 on zero, 1000 on nonzero, 1101 on greater, 1001 on greater or zero. The next step is a fetch in either case.
- R9: Opcodes 0010, 0110 and 1110 read bits 8:6 into the ALU and load the shift count from bits 2:0. They then assert `shift_en` for exactly that many cycles with `shift_mode` 01, 10 or 11 respectively. One idle step follows, then a write step asserting `alu_to_bus` and `rf_we` to bits 11:9.
- R10: Opcodes 0111 and 1111 raise `clk_gate` in their first execute step. It stays high, with every other strobe low, until reset.
- R11: At most one of `alu_to_bus`, `in_to_bus`, `mem_rd` and `rf_wr_imm` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Byte read from memory at the current address |
| alu_zero | input | 1 | ALU operand A equals zero |
| alu_gt | input | 1 | ALU operand A is greater than zero, signed |
| pc_inc | output | 1 | Advance the program counter |
| pc_load | output | 1 | Load the program counter from `addr_field` |
| addr_field | output | 9 | Absolute address field of the instruction |
| rf_rd_en | output | 1 | Register file drives its read ports |
| rf_sel_a | output | 3 | Read select for operand A |
| rf_sel_b | output | 3 | Read select for operand B |
| alu_load | output | 1 | Capture operands into the ALU |
| alu_b_imm | output | 1 | ALU operand B taken from `lit_data` |
| alu_exec | output | 1 | Apply `alu_op` to the held operands |
| alu_op | output | 3 | ALU operation code |
| alu_to_bus | output | 1 | ALU result drives the write bus |
| rf_we | output | 1 | Write the register at `rf_waddr` |
| rf_waddr | output | 3 | Register write select |
| rf_wr_imm | output | 1 | Register write data taken from `lit_data` |
| lit_data | output | 8 | Literal from the instruction |
| in_to_bus | output | 1 | Input pins drive the write bus |
| bus_to_out | output | 1 | Capture operand A into the output register |
| mem_use_ir | output | 1 | Memory address from `addr_field` instead of the program counter |
| mem_rd | output | 1 | Memory data drives the write bus |
| mem_wr | output | 1 | Write operand A to memory |
| shift_en | output | 1 | Shift the ALU accumulator by one position |
| shift_mode | output | 2 | Shift kind: 01 left, 10 right, 11 rotate right |
| clk_gate | output | 1 | Halt: gate the processor clock |

## Verification
Some properties are checked on every cycle. These are the sticky, silent halt, the pairing of fetch steps, the exclusive use of the write bus, the step counter holding still while a shift is issued, and the return to a fetch after every jump load and every ALU write-back. Only the bench scenarios can show the content of each step sequence. That covers operand selects, literal sign extension, the flags-to-ALU code mapping, and the shift count for zero, middle and full counts. It also covers taken and untaken jumps under each status combination, the reserved encodings having no effect, and recovery from a halt through reset.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

  typedef enum logic [3:0] {
    OP_ARITH = 4'h0, OP_LOAD  = 4'h1, OP_SHL  = 4'h2, OP_SET   = 4'h3,
    OP_IO    = 4'h4, OP_STORE = 4'h5, OP_SHR  = 4'h6, OP_HALT  = 4'h7,
    OP_JNZ   = 4'h8, OP_JGEZ  = 4'h9, OP_RSVD = 4'hA, OP_NOP   = 4'hB,
    OP_JZ    = 4'hC, OP_JGTZ  = 4'hD, OP_ROR  = 4'hE, OP_HALT2 = 4'hF
  } op_e;

  typedef enum logic [2:0] {
    AF_ADDI = 3'd0, AF_ADD = 3'd1, AF_SUB = 3'd2, AF_OR   = 3'd3,
    AF_AND  = 3'd4, AF_NOT = 3'd5, AF_XOR = 3'd6, AF_RSVD = 3'd7
  } afn_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0, ALU_OR  = 3'd1, ALU_ADD = 3'd2, ALU_SUB = 3'd3,
    ALU_PASS = 3'd4, ALU_NOT = 3'd5, ALU_XOR = 3'd6
  } alu_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0, SH_LEFT = 2'd1, SH_RIGHT = 2'd2, SH_ROT = 2'd3
  } sh_e;

  function automatic alu_e afn_to_alu(input afn_e f);
    case (f)
      AF_ADDI, AF_ADD: return ALU_ADD;
      AF_SUB:          return ALU_SUB;
      AF_OR:           return ALU_OR;
      AF_AND:          return ALU_AND;
      AF_NOT:          return ALU_NOT;
      AF_XOR:          return ALU_XOR;
      default:         return ALU_PASS;
    endcase
  endfunction

endpackage

// File: rtl/mc_seq_ir.sv
module mc_seq_ir #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 2,
  localparam int INSTR_W = DATA_W * NBYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NBYTES-1:0]  byte_ld,
  input  logic [DATA_W-1:0]  din,
  output logic [INSTR_W-1:0] ir
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)             byte_q <= '0;
      else if (byte_ld[g]) byte_q <= din;
    end
    assign ir[g*DATA_W +: DATA_W] = byte_q;
  end

endmodule

// File: rtl/mc_seq_steps.sv
module mc_seq_steps #(
  parameter int STEP_W  = 3,
  parameter int SHAMT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_clr,
  input  logic               step_hold,
  input  logic               halt_set,
  input  logic               cnt_load,
  input  logic               cnt_dec,
  input  logic [SHAMT_W-1:0] cnt_val,
  output logic [STEP_W-1:0]  step,
  output logic               cnt_zero,
  output logic               halted
);

  logic [STEP_W-1:0]  step_r;
  logic [SHAMT_W-1:0] cnt_r;
  logic               halt_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_r <= '0;
      cnt_r  <= '0;
      halt_r <= 1'b0;
    end else if (!halt_r) begin
      if (halt_set) halt_r <= 1'b1;
      if (step_clr)                     step_r <= '0;
      else if (!step_hold && !halt_set) step_r <= step_r + 1'b1;
      if (cnt_load)     cnt_r <= cnt_val;
      else if (cnt_dec) cnt_r <= cnt_r - 1'b1;
    end
  end

  assign step     = step_r;
  assign cnt_zero = (cnt_r == '0);
  assign halted   = halt_r;

endmodule

// File: rtl/mc_seq_decode.sv
module mc_seq_decode
  import mc_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 9,
  parameter int RSEL_W  = 3,
  parameter int STEP_W  = 3,
  parameter int SHAMT_W = 3,
  localparam int INSTR_W = 2 * DATA_W,
  localparam int OPC_W   = 4,
  localparam int FLAG_W  = 3,
  localparam int OPC_LSB = INSTR_W - OPC_W,
  localparam int R0_LSB  = OPC_LSB - RSEL_W,
  localparam int R1_LSB  = R0_LSB - RSEL_W,
  localparam int R2_LSB  = R1_LSB - RSEL_W,
  localparam int L6_W    = R0_LSB - FLAG_W
) (
  input  logic [INSTR_W-1:0] ir,
  input  logic [STEP_W-1:0]  step,
  input  logic               halted,
  input  logic               cnt_zero,
  input  logic               alu_zero,
  input  logic               alu_gt,
  output logic [1:0]         byte_ld,
  output logic               step_clr,
  output logic               step_hold,
  output logic               halt_set,
  output logic               cnt_load,
  output logic               cnt_dec,
  output logic [SHAMT_W-1:0] cnt_val,
  output logic               pc_inc,
  output logic               pc_load,
  output logic [ADDR_W-1:0]  addr_field,
  output logic               rf_rd_en,
  output logic [RSEL_W-1:0]  rf_sel_a,
  output logic [RSEL_W-1:0]  rf_sel_b,
  output logic               alu_load,
  output logic               alu_b_imm,
  output logic               alu_exec,
  output logic [2:0]         alu_op,
  output logic               alu_to_bus,
  output logic               rf_we,
  output logic [RSEL_W-1:0]  rf_waddr,
  output logic               rf_wr_imm,
  output logic [DATA_W-1:0]  lit_data,
  output logic               in_to_bus,
  output logic               bus_to_out,
  output logic               mem_use_ir,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               shift_en,
  output logic [1:0]         shift_mode,
  output logic               clk_gate
);

  localparam logic [STEP_W-1:0] S_LO  = STEP_W'(0);
  localparam logic [STEP_W-1:0] S_HI  = STEP_W'(1);
  localparam logic [STEP_W-1:0] S_EX0 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S_EX1 = STEP_W'(3);

  op_e                opc;
  afn_e               fn;
  logic [RSEL_W-1:0]  r0, r1;
  logic               jmp_take;

  assign opc = op_e'(ir[OPC_LSB +: OPC_W]);
  assign fn  = afn_e'(ir[FLAG_W-1:0]);
  assign r0  = ir[R0_LSB +: RSEL_W];
  assign r1  = ir[R1_LSB +: RSEL_W];

  always_comb begin
    case (opc)
      OP_JZ:   jmp_take = alu_zero;
      OP_JNZ:  jmp_take = !alu_zero;
      OP_JGTZ: jmp_take = alu_gt;
      OP_JGEZ: jmp_take = alu_gt | alu_zero;
      default: jmp_take = 1'b0;
    endcase
  end

  // Fields that are always presented; strobes say when they matter.
  assign addr_field = ir[ADDR_W-1:0];
  assign rf_sel_b   = ir[R2_LSB +: RSEL_W];
  assign rf_waddr   = r0;
  assign alu_op     = afn_to_alu(fn);
  assign cnt_val    = ir[SHAMT_W-1:0];
  assign lit_data   = (opc == OP_ARITH)
                    ? {{(DATA_W-L6_W){ir[FLAG_W+L6_W-1]}}, ir[FLAG_W +: L6_W]}
                    : ir[DATA_W-1:0];

  always_comb begin
    case (opc)
      OP_SHL:  shift_mode = SH_LEFT;
      OP_SHR:  shift_mode = SH_RIGHT;
      OP_ROR:  shift_mode = SH_ROT;
      default: shift_mode = SH_NONE;
    endcase
  end

  always_comb begin
    byte_ld    = '0;
    step_clr   = 1'b0;
    step_hold  = 1'b0;
    halt_set   = 1'b0;
    cnt_load   = 1'b0;
    cnt_dec    = 1'b0;
    pc_inc     = 1'b0;
    pc_load    = 1'b0;
    rf_rd_en   = 1'b0;
    rf_sel_a   = r0;
    alu_load   = 1'b0;
    alu_b_imm  = 1'b0;
    alu_exec   = 1'b0;
    alu_to_bus = 1'b0;
    rf_we      = 1'b0;
    rf_wr_imm  = 1'b0;
    in_to_bus  = 1'b0;
    bus_to_out = 1'b0;
    mem_use_ir = 1'b0;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    shift_en   = 1'b0;

    if (halted) begin
      // frozen
    end else if (step == S_LO) begin
      pc_inc     = 1'b1;
      byte_ld[0] = 1'b1;
    end else if (step == S_HI) begin
      pc_inc     = 1'b1;
      byte_ld[1] = 1'b1;
    end else begin
      case (opc)
        OP_ARITH: begin
          if (fn == AF_RSVD) begin
            step_clr = 1'b1;
          end else if (step == S_EX0) begin
            rf_rd_en  = 1'b1;
            alu_load  = 1'b1;
            alu_b_imm = (fn == AF_ADDI);
            rf_sel_a  = (fn == AF_ADDI) ? r0 : r1;
          end else if (step == S_EX1) begin
            alu_exec = 1'b1;
          end else begin
            alu_to_bus = 1'b1;
            rf_we      = 1'b1;
            step_clr   = 1'b1;
          end
        end
        OP_IO: begin
          if (ir[0]) begin
            rf_rd_en   = 1'b1;
            bus_to_out = 1'b1;
          end else begin
            in_to_bus = 1'b1;
            rf_we     = 1'b1;
          end
          step_clr = 1'b1;
        end
        OP_LOAD: begin
          mem_use_ir = 1'b1;
          mem_rd     = 1'b1;
          rf_we      = 1'b1;
          step_clr   = 1'b1;
        end
        OP_STORE: begin
          rf_rd_en   = 1'b1;
          mem_use_ir = 1'b1;
          mem_wr     = 1'b1;
          step_clr   = 1'b1;
        end
        OP_SET: begin
          rf_we     = 1'b1;
          rf_wr_imm = 1'b1;
          step_clr  = 1'b1;
        end
        OP_JZ, OP_JNZ, OP_JGTZ, OP_JGEZ: begin
          if (step == S_EX0) begin
            rf_rd_en = 1'b1;
            alu_load = 1'b1;
          end else begin
            pc_load  = jmp_take;
            step_clr = 1'b1;
          end
        end
        OP_SHL, OP_SHR, OP_ROR: begin
          if (step == S_EX0) begin
            rf_rd_en = 1'b1;
            rf_sel_a = r1;
            alu_load = 1'b1;
            cnt_load = 1'b1;
          end else if (step == S_EX1) begin
            if (!cnt_zero) begin
              shift_en  = 1'b1;
              cnt_dec   = 1'b1;
              step_hold = 1'b1;
            end
          end else begin
            alu_to_bus = 1'b1;
            rf_we      = 1'b1;
            step_clr   = 1'b1;
          end
        end
        OP_HALT, OP_HALT2: begin
          halt_set = 1'b1;
        end
        default: begin
          step_clr = 1'b1;
        end
      endcase
    end
  end

  assign clk_gate = halted | halt_set;

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 9,
  parameter int RSEL_W  = 3,
  parameter int STEP_W  = 3,
  parameter int SHAMT_W = 3,
  localparam int INSTR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              alu_zero,
  input  logic              alu_gt,
  output logic              pc_inc,
  output logic              pc_load,
  output logic [ADDR_W-1:0] addr_field,
  output logic              rf_rd_en,
  output logic [RSEL_W-1:0] rf_sel_a,
  output logic [RSEL_W-1:0] rf_sel_b,
  output logic              alu_load,
  output logic              alu_b_imm,
  output logic              alu_exec,
  output logic [2:0]        alu_op,
  output logic              alu_to_bus,
  output logic              rf_we,
  output logic [RSEL_W-1:0] rf_waddr,
  output logic              rf_wr_imm,
  output logic [DATA_W-1:0] lit_data,
  output logic              in_to_bus,
  output logic              bus_to_out,
  output logic              mem_use_ir,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              shift_en,
  output logic [1:0]        shift_mode,
  output logic              clk_gate
);

  logic [INSTR_W-1:0] ir_q;
  logic [1:0]         byte_ld;
  logic [STEP_W-1:0]  step_q;
  logic               halted_q;
  logic               cnt_zero;
  logic               step_clr, step_hold, halt_set, cnt_load, cnt_dec;
  logic [SHAMT_W-1:0] cnt_val;

  mc_seq_ir #(.DATA_W(DATA_W), .NBYTES(2)) u_ir (
    .clk     (clk),
    .rst     (rst),
    .byte_ld (byte_ld),
    .din     (mem_rdata),
    .ir      (ir_q)
  );

  mc_seq_steps #(.STEP_W(STEP_W), .SHAMT_W(SHAMT_W)) u_steps (
    .clk       (clk),
    .rst       (rst),
    .step_clr  (step_clr),
    .step_hold (step_hold),
    .halt_set  (halt_set),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec),
    .cnt_val   (cnt_val),
    .step      (step_q),
    .cnt_zero  (cnt_zero),
    .halted    (halted_q)
  );

  mc_seq_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RSEL_W(RSEL_W),
    .STEP_W(STEP_W), .SHAMT_W(SHAMT_W)
  ) u_dec (
    .ir         (ir_q),
    .step       (step_q),
    .halted     (halted_q),
    .cnt_zero   (cnt_zero),
    .alu_zero   (alu_zero),
    .alu_gt     (alu_gt),
    .byte_ld    (byte_ld),
    .step_clr   (step_clr),
    .step_hold  (step_hold),
    .halt_set   (halt_set),
    .cnt_load   (cnt_load),
    .cnt_dec    (cnt_dec),
    .cnt_val    (cnt_val),
    .pc_inc     (pc_inc),
    .pc_load    (pc_load),
    .addr_field (addr_field),
    .rf_rd_en   (rf_rd_en),
    .rf_sel_a   (rf_sel_a),
    .rf_sel_b   (rf_sel_b),
    .alu_load   (alu_load),
    .alu_b_imm  (alu_b_imm),
    .alu_exec   (alu_exec),
    .alu_op     (alu_op),
    .alu_to_bus (alu_to_bus),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wr_imm  (rf_wr_imm),
    .lit_data   (lit_data),
    .in_to_bus  (in_to_bus),
    .bus_to_out (bus_to_out),
    .mem_use_ir (mem_use_ir),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .shift_en   (shift_en),
    .shift_mode (shift_mode),
    .clk_gate   (clk_gate)
  );

endmodule

// File: rtl/mc_sequencer_chk.sv
module mc_sequencer_chk #(
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              pc_inc,
  input logic              pc_load,
  input logic              rf_we,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic              bus_to_out,
  input logic              alu_to_bus,
  input logic              in_to_bus,
  input logic              rf_wr_imm,
  input logic              shift_en,
  input logic              clk_gate,
  input logic [STEP_W-1:0] step_q
);

  // R2
  fetch_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (step_q == '0 && !clk_gate) |=> (step_q == STEP_W'(1) && pc_inc));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    clk_gate |=> clk_gate);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    clk_gate |-> !(pc_inc || pc_load || rf_we || mem_wr || bus_to_out || shift_en));

  // R11
  bus_single_src_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({alu_to_bus, in_to_bus, mem_rd, rf_wr_imm}));

  // R9
  shift_stall_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> $stable(step_q));

  // R8
  jump_refetch_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> (pc_inc && step_q == '0));

  // R3
  writeback_end_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we && alu_to_bus) |=> (step_q == '0));

endmodule

bind mc_sequencer mc_sequencer_chk u_chk (.*);

// File: tb/mc_sequencer_tb.sv
module mc_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_rdata = '0;
  logic       alu_zero = 1'b0;
  logic       alu_gt = 1'b0;

  logic       pc_inc, pc_load, rf_rd_en, alu_load, alu_b_imm, alu_exec;
  logic       alu_to_bus, rf_we, rf_wr_imm, in_to_bus, bus_to_out;
  logic       mem_use_ir, mem_rd, mem_wr, shift_en, clk_gate;
  logic [8:0] addr_field;
  logic [2:0] rf_sel_a, rf_sel_b, alu_op, rf_waddr;
  logic [7:0] lit_data;
  logic [1:0] shift_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_sequencer u_dut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .alu_zero(alu_zero), .alu_gt(alu_gt),
    .pc_inc(pc_inc), .pc_load(pc_load), .addr_field(addr_field),
    .rf_rd_en(rf_rd_en), .rf_sel_a(rf_sel_a), .rf_sel_b(rf_sel_b),
    .alu_load(alu_load), .alu_b_imm(alu_b_imm), .alu_exec(alu_exec), .alu_op(alu_op),
    .alu_to_bus(alu_to_bus), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wr_imm(rf_wr_imm),
    .lit_data(lit_data), .in_to_bus(in_to_bus), .bus_to_out(bus_to_out),
    .mem_use_ir(mem_use_ir), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .shift_en(shift_en), .shift_mode(shift_mode), .clk_gate(clk_gate)
  );

  typedef struct packed {
    logic pc_inc, pc_load, rf_rd_en, alu_load, alu_b_imm, alu_exec;
    logic alu_to_bus, rf_we, rf_wr_imm, in_to_bus, bus_to_out;
    logic mem_use_ir, mem_rd, mem_wr, shift_en, clk_gate;
    logic [2:0] sel_a, sel_b, waddr, op;
    logic [1:0] sh;
    logic [8:0] addr;
    logic [7:0] lit;
  } ctl_t;

  ctl_t       exp_q[$];
  string      tag_q[$];
  logic [7:0] byte_q[$];
  int         checks = 0;
  int         errors = 0;
  bit         fresh  = 1'b0;

  function automatic ctl_t observe();
    ctl_t o = '0;
    o.pc_inc = pc_inc;   o.pc_load = pc_load;   o.rf_rd_en = rf_rd_en;
    o.alu_load = alu_load; o.alu_b_imm = alu_b_imm; o.alu_exec = alu_exec;
    o.alu_to_bus = alu_to_bus; o.rf_we = rf_we; o.rf_wr_imm = rf_wr_imm;
    o.in_to_bus = in_to_bus; o.bus_to_out = bus_to_out; o.mem_use_ir = mem_use_ir;
    o.mem_rd = mem_rd; o.mem_wr = mem_wr; o.shift_en = shift_en; o.clk_gate = clk_gate;
    o.sel_a = rf_rd_en ? rf_sel_a : 3'd0;
    o.sel_b = rf_rd_en ? rf_sel_b : 3'd0;
    o.waddr = rf_we ? rf_waddr : 3'd0;
    o.op    = alu_exec ? alu_op : 3'd0;
    o.sh    = shift_en ? shift_mode : 2'd0;
    o.addr  = (pc_load | mem_use_ir) ? addr_field : 9'd0;
    o.lit   = (alu_b_imm | rf_wr_imm) ? lit_data : 8'd0;
    return o;
  endfunction

  task automatic push(input string t, input logic [7:0] b, input ctl_t v);
    exp_q.push_back(v);
    tag_q.push_back(t);
    byte_q.push_back(b);
  endtask

  // Compare at the falling edge, then present this cycle's memory byte.
  task automatic drain();
    while (exp_q.size() > 0) begin
      ctl_t  e = exp_q.pop_front();
      string t = tag_q.pop_front();
      ctl_t  o = observe();
      checks++;
      if (o !== e) begin
        errors++;
        $display("FAIL %s actual %h expected %h", t, o, e);
      end
      mem_rdata = byte_q.pop_front();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fresh = 1'b1;
  endtask

  function automatic logic [2:0] alu_code(input logic [2:0] f);
    case (f)
      3'd0, 3'd1: return 3'b010;
      3'd2:       return 3'b011;
      3'd3:       return 3'b001;
      3'd4:       return 3'b000;
      3'd5:       return 3'b101;
      default:    return 3'b110;
    endcase
  endfunction

  // Reference: expected control sequence of one instruction.
  task automatic run(input logic [15:0] ins, input logic z, input logic gt, input int halt_cyc);
    ctl_t v;
    logic [3:0] opc = ins[15:12];
    logic [2:0] r0 = ins[11:9], r1 = ins[8:6], r2 = ins[5:3], fl = ins[2:0];
    bit take;
    alu_zero = z;
    alu_gt   = gt;
    v = '0; v.pc_inc = 1'b1;
    push(fresh ? "R1" : "R2", ins[7:0], v);   // R1 first fetch after reset, R2 fetch
    push("R2", ins[15:8], v);
    fresh = 1'b0;
    case (opc)
      4'h0: begin
        if (fl == 3'd7) begin
          v = '0; push("R4", 8'h00, v);
        end else begin
          v = '0; v.rf_rd_en = 1; v.alu_load = 1; v.sel_b = r2;
          v.sel_a = (fl == 0) ? r0 : r1;
          if (fl == 0) begin v.alu_b_imm = 1; v.lit = {{2{ins[8]}}, ins[8:3]}; end
          push("R3", 8'h00, v);
          v = '0; v.alu_exec = 1; v.op = alu_code(fl); push("R3", 8'h00, v);
          v = '0; v.alu_to_bus = 1; v.rf_we = 1; v.waddr = r0; push("R3", 8'h00, v);
        end
      end
      4'h4: begin
        v = '0;
        if (fl[0]) begin v.rf_rd_en = 1; v.sel_a = r0; v.sel_b = r2; v.bus_to_out = 1; end
        else begin v.in_to_bus = 1; v.rf_we = 1; v.waddr = r0; end
        push("R5", 8'h00, v);
      end
      4'h1: begin
        v = '0; v.mem_use_ir = 1; v.mem_rd = 1; v.rf_we = 1; v.waddr = r0; v.addr = ins[8:0];
        push("R6", 8'h00, v);
      end
      4'h5: begin
        v = '0; v.rf_rd_en = 1; v.sel_a = r0; v.sel_b = r2; v.mem_use_ir = 1; v.mem_wr = 1;
        v.addr = ins[8:0];
        push("R6", 8'h00, v);
      end
      4'h3: begin
        v = '0; v.rf_we = 1; v.rf_wr_imm = 1; v.waddr = r0; v.lit = ins[7:0];
        push("R7", 8'h00, v);
      end
      4'h8, 4'h9, 4'hC, 4'hD: begin
        v = '0; v.rf_rd_en = 1; v.alu_load = 1; v.sel_a = r0; v.sel_b = r2;
        push("R8", 8'h00, v);
        case (opc)
          4'hC:    take = z;
          4'h8:    take = !z;
          4'hD:    take = gt;
          default: take = gt | z;
        endcase
        v = '0;
        if (take) begin v.pc_load = 1; v.addr = ins[8:0]; end
        push("R8", 8'h00, v);
      end
      4'h2, 4'h6, 4'hE: begin
        v = '0; v.rf_rd_en = 1; v.alu_load = 1; v.sel_a = r1; v.sel_b = r2;
        push("R9", 8'h00, v);
        for (int k = 0; k < int'(fl); k++) begin
          v = '0; v.shift_en = 1;
          v.sh = (opc == 4'h2) ? 2'b01 : (opc == 4'h6) ? 2'b10 : 2'b11;
          push("R9", 8'h00, v);
        end
        v = '0; push("R9", 8'h00, v);
        v = '0; v.alu_to_bus = 1; v.rf_we = 1; v.waddr = r0; push("R9", 8'h00, v);
      end
      4'h7, 4'hF: begin
        for (int k = 0; k <= halt_cyc; k++) begin
          v = '0; v.clk_gate = 1; push("R10", 8'h00, v);
        end
      end
      default: begin
        v = '0; push("R4", 8'h00, v);
      end
    endcase
    drain();
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] a,
                                      input logic [2:0] b, input logic [2:0] c,
                                      input logic [2:0] f);
    return {op, a, b, c, f};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R3 register ALU operations
    run(enc(4'h0, 3'd3, 3'd1, 3'd2, 3'd1), 0, 0, 0);
    run(16'h0FF0, 0, 0, 0);                            // ADDI r7, -2
    run(enc(4'h0, 3'd1, 3'd0, 3'd5, 3'd0), 0, 0, 0);   // ADDI positive literal
    run(enc(4'h0, 3'd2, 3'd4, 3'd6, 3'd2), 0, 0, 0);
    run(enc(4'h0, 3'd5, 3'd7, 3'd1, 3'd3), 0, 0, 0);
    run(enc(4'h0, 3'd6, 3'd2, 3'd3, 3'd4), 0, 0, 0);
    run(enc(4'h0, 3'd0, 3'd5, 3'd0, 3'd5), 0, 0, 0);
    run(enc(4'h0, 3'd4, 3'd6, 3'd7, 3'd6), 0, 0, 0);
    // R4 reserved and no-op encodings
    run(enc(4'h0, 3'd4, 3'd6, 3'd7, 3'd7), 0, 0, 0);
    run(16'hB5A5, 0, 0, 0);
    run(16'hAFFF, 0, 0, 0);
    // R5 IO
    run(enc(4'h4, 3'd3, 3'd0, 3'd0, 3'd0), 0, 0, 0);
    run(16'h4401, 0, 0, 0);
    // R6 memory
    run({4'h1, 3'd5, 9'h1A4}, 0, 0, 0);
    run({4'h5, 3'd2, 9'h03C}, 0, 0, 0);
    // R7 literal write
    run({4'h3, 3'd6, 1'b0, 8'hC3}, 0, 0, 0);
    // R8 jumps, taken and not taken
    run({4'hC, 3'd1, 9'h100}, 1, 0, 0);
    run({4'hC, 3'd1, 9'h100}, 0, 1, 0);
    run({4'h8, 3'd2, 9'h0FF}, 0, 0, 0);
    run({4'h8, 3'd2, 9'h0FF}, 1, 0, 0);
    run(16'hD7A4, 0, 1, 0);
    run(16'hD7A4, 0, 0, 0);
    run({4'h9, 3'd4, 9'h011}, 1, 0, 0);
    run({4'h9, 3'd4, 9'h011}, 0, 1, 0);
    run({4'h9, 3'd4, 9'h011}, 0, 0, 0);
    // R9 shifts with counts 5, 0, 7 and 1
    run(enc(4'h2, 3'd1, 3'd2, 3'd0, 3'd5), 0, 0, 0);
    run(16'h68C0, 0, 0, 0);
    run(enc(4'hE, 3'd7, 3'd0, 3'd0, 3'd7), 0, 0, 0);
    run(16'h68C1, 0, 0, 0);
    // R10 halt, then reset recovers (R1)
    run(16'h7000, 0, 0, 5);
    do_reset();
    run(16'hB000, 0, 0, 0);
    run(16'hF123, 0, 0, 3);
    do_reset();
    run(enc(4'h0, 3'd3, 3'd1, 3'd2, 3'd2), 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule